// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Per-Source Trigger Configuration

This block collects interrupt sources from four peripheral groups of a small mixed-signal device and presents them to a host as one interrupt line. Each group holds up to eight sources. Each source is brought into the clock domain through a synchronizer. It is then qualified as a level or an edge event, with a high, low or both-sided sense. The result is held in a latched status bit until the host acknowledges it.

The host reaches the block over a simple synchronous register bus with a 16-bit address, 8-bit data, and separate write and read strobes. Enables are never written directly. One register turns bits on by writing ones, and a second register turns bits off the same way. A summary register holds one bit per group, so the host can find the interrupting group with a single read. The combined output is the registered OR of that summary.

Top module: `irq_hub`

## Requirements
- R1: Group g's registers sit at its base (group 0: 0x0900, group 1: 0x2400, group 2: 0xC000, group 3: 0xC100) plus an offset: raw 0x10, trigger type 0x11, positive sense 0x12, negative sense 0x13, acknowledge 0x14, enable-on 0x15, enable-off 0x16, latched 0x18. Any other address reads as 0x00, and writes to it change nothing.
- R2: The raw register shows each source's input after a two-flop synchronizer.
- R3: With the type bit at 1 (edge), positive sense latches on a 0-to-1 change of the synchronized input. Negative sense latches on a 1-to-0 change. Both set latches on either change.
- R4: With the type bit at 0 (level), positive sense latches while the input is 1, and negative sense latches while it is 0. An acknowledged level source latches again on the next clock if its condition still holds.
- R5: Writing 1 to an acknowledge bit clears that latched bit. Bits written 0 are untouched, and a trigger in the same cycle wins over the clear.
- R6: Writing 1 to an enable-on bit enables that source, and writing 1 to an enable-off bit disables it. Zero bits have no effect. Both addresses read back the enable mask.
- R7: The summary register at 0x0550 has bit g (g = 0..3) set when group g has any source both latched and enabled. Bits 7..4 read 0.
- R8: host_irq is active high and equals the OR of the summary bits one clock later.
- R9: Group 0 has sources on bits 0..4 and is fixed to rising edge. Its type and positive-sense registers read 0x1F, its negative-sense register reads 0x00, and writes to them are ignored. Groups 1..3 have a single source on bit 0. Unimplemented bits read 0 in every register.
- R10: After reset, every enable, latched and configurable type/sense bit is 0, and host_irq is 0.
- R11: bus_rdata carries the addressed register's value from the clock edge that samples bus_rd, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| src_in | input | 32 | Raw sources, group g bit b at index 8*g+b |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
The assertions assume that bus_wr and bus_rd are never high together, and that a single write addresses only one register. Under that assumption, the checks on enable-on and acknowledge can relate the next state to the data written. The edge check takes src_in as arbitrary, because any source change passes through the synchronizer before it can be seen. The stimulus holds each strobe for exactly one cycle and never overlaps a read with a write. It changes sources only between bus accesses and waits several cycles before it reads the result.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int NUM_GRP    = 4;
  localparam int SYNC_DEPTH = 2;

  localparam logic [7:0] OFF_RAW   = 8'h10;
  localparam logic [7:0] OFF_TYPE  = 8'h11;
  localparam logic [7:0] OFF_POS   = 8'h12;
  localparam logic [7:0] OFF_NEG   = 8'h13;
  localparam logic [7:0] OFF_ACK   = 8'h14;
  localparam logic [7:0] OFF_ENON  = 8'h15;
  localparam logic [7:0] OFF_ENOFF = 8'h16;
  localparam logic [7:0] OFF_LATCH = 8'h18;

  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 16'h0550;

  // Base address of each group; the low byte is always zero.
  function automatic logic [ADDR_W-1:0] grp_base(input int g);
    case (g)
      0:       return 16'h0900;
      1:       return 16'h2400;
      2:       return 16'hC000;
      default: return 16'hC100;
    endcase
  endfunction

  // Implemented source bits per group.
  function automatic logic [DATA_W-1:0] grp_impl(input int g);
    return (g == 0) ? 8'h1F : 8'h01;
  endfunction

  // Trigger condition per bit: edge or level, positive and/or negative sense.
  function automatic logic [DATA_W-1:0] trig(
    input logic [DATA_W-1:0] typ, input logic [DATA_W-1:0] pos,
    input logic [DATA_W-1:0] neg, input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] prv);
    logic [DATA_W-1:0] edg, lvl;
    edg = (pos & cur & ~prv) | (neg & ~cur & prv);
    lvl = (pos & cur) | (neg & ~cur);
    return (typ & edg) | (~typ & lvl);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/irq_group.sv
module irq_group
  import irq_hub_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL       = 8'h01,
  parameter bit                FIXED_RISE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lvl,
  input  logic              sel,
  input  logic [7:0]        off,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              pend
);
  logic [DATA_W-1:0] typ, pos, neg;
  logic [DATA_W-1:0] en_q, lat_q, prv_q, evt, wbits;
  logic              ack_wr, on_wr, off_wr;

  assign wbits  = wdata & IMPL;
  assign ack_wr = sel && wr && (off == OFF_ACK);
  assign on_wr  = sel && wr && (off == OFF_ENON);
  assign off_wr = sel && wr && (off == OFF_ENOFF);

  generate
    if (FIXED_RISE) begin : g_fixed
      assign typ = IMPL;
      assign pos = IMPL;
      assign neg = '0;
    end else begin : g_cfg
      logic [DATA_W-1:0] typ_q, pos_q, neg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          typ_q <= '0;
          pos_q <= '0;
          neg_q <= '0;
        end else if (sel && wr) begin
          if (off == OFF_TYPE) typ_q <= wbits;
          if (off == OFF_POS)  pos_q <= wbits;
          if (off == OFF_NEG)  neg_q <= wbits;
        end
      end
      assign typ = typ_q;
      assign pos = pos_q;
      assign neg = neg_q;
    end
  endgenerate

  assign evt = trig(typ, pos, neg, lvl, prv_q) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lat_q <= '0;
      prv_q <= '0;
    end else begin
      prv_q <= lvl;
      lat_q <= (lat_q & ~(ack_wr ? wbits : '0)) | evt;
      if (on_wr)       en_q <= en_q | wbits;
      else if (off_wr) en_q <= en_q & ~wbits;
    end
  end

  assign pend = |(lat_q & en_q);

  always_comb begin
    rd_val = '0;
    if (sel) begin
      case (off)
        OFF_RAW:              rd_val = lvl & IMPL;
        OFF_TYPE:             rd_val = typ;
        OFF_POS:              rd_val = pos;
        OFF_NEG:              rd_val = neg;
        OFF_ENON, OFF_ENOFF:  rd_val = en_q;
        OFF_LATCH:            rd_val = lat_q;
        default:              rd_val = '0;
      endcase
    end
  end

  assert_enable_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    on_wr |=> ((en_q & $past(wbits)) == $past(wbits)));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((lat_q & $past(wbits & ~evt)) == '0));

  assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & ~$past(lat_q) & $past(typ)) & ~($past(lvl) ^ $past(prv_q))) == '0);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NGRP = NUM_GRP,
  parameter int SYNC = SYNC_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NGRP*DATA_W-1:0] src_in,
  output logic                   host_irq
);
  localparam int SRC_BITS = NGRP * DATA_W;

  logic [SRC_BITS-1:0] src_s;
  logic [DATA_W-1:0]   grp_rd [NGRP];
  logic [NGRP-1:0]     grp_sel, summary;
  logic [DATA_W-1:0]   rd_comb;
  logic                off_known, mapped;

  irq_sync #(.W(SRC_BITS), .DEPTH(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_s));

  always_comb begin
    case (bus_addr[7:0])
      OFF_RAW, OFF_TYPE, OFF_POS, OFF_NEG, OFF_ACK,
      OFF_ENON, OFF_ENOFF, OFF_LATCH: off_known = 1'b1;
      default:                        off_known = 1'b0;
    endcase
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] BASE = grp_base(g);
      assign grp_sel[g] = (bus_addr[15:8] == BASE[15:8]);
      irq_group #(.IMPL(grp_impl(g)), .FIXED_RISE(g == 0)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .lvl(src_s[g*DATA_W +: DATA_W]),
        .sel(grp_sel[g]), .off(bus_addr[7:0]),
        .wr(bus_wr), .wdata(bus_wdata),
        .rd_val(grp_rd[g]), .pend(summary[g]));
    end
  endgenerate

  assign mapped = (bus_addr == SUMMARY_ADDR) || ((|grp_sel) && off_known);

  always_comb begin
    rd_comb = '0;
    if (bus_addr == SUMMARY_ADDR) rd_comb = DATA_W'(summary);
    else for (int g = 0; g < NGRP; g++) rd_comb = rd_comb | grp_rd[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      host_irq  <= 1'b0;
    end else begin
      host_irq <= |summary;
      if (bus_rd) bus_rdata <= rd_comb;
    end
  end

  assert_irq_follows_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == $past(|summary));

  assert_unmapped_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [31:0] src_in = '0;
  logic        host_irq;
  logic        rd_seen = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_in(src_in), .host_irq(host_irq));

  function automatic logic [15:0] ra(input int g, input logic [7:0] off);
    logic [15:0] b;
    case (g)
      0: b = 16'h0900; 1: b = 16'h2400; 2: b = 16'hC000; default: b = 16'hC100;
    endcase
    return b + {8'h00, off};
  endfunction

  // R11: the read result is valid after the edge that samples bus_rd.
  always @(posedge clk) rd_seen <= bus_rd;

  // Monitor: pop the oldest expected item whenever a read result appears.
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (host_irq !== e) begin
      fails++;
      $display("FAIL %s: host_irq=%0b expected=%0b", t, host_irq, e);
    end
  endtask

  task automatic finish_run();
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state, R9 fixed group-0 configuration
    chk_irq(1'b0, "R10 host_irq after reset");
    rd(16'h0550, 8'h00, "R10 summary after reset");
    rd(ra(0, 8'h15), 8'h00, "R10 group0 enable after reset");
    rd(ra(1, 8'h11), 8'h00, "R10 group1 type after reset");
    rd(ra(0, 8'h11), 8'h1F, "R9 group0 type fixed");
    rd(ra(0, 8'h12), 8'h1F, "R9 group0 positive fixed");
    rd(ra(0, 8'h13), 8'h00, "R9 group0 negative fixed");
    wr(ra(0, 8'h11), 8'h00);
    rd(ra(0, 8'h11), 8'h1F, "R9 group0 type write ignored");

    // R6 enable-on / enable-off
    wr(ra(0, 8'h15), 8'h05);
    rd(ra(0, 8'h15), 8'h05, "R6 enable-on readback");
    rd(ra(0, 8'h16), 8'h05, "R6 enable-off readback");
    wr(ra(0, 8'h15), 8'h00);
    rd(ra(0, 8'h15), 8'h05, "R6 zero enable-on write no effect");
    wr(ra(0, 8'h16), 8'h04);
    rd(ra(0, 8'h15), 8'h01, "R6 enable-off clears bit");
    wr(ra(0, 8'h16), 8'h00);
    rd(ra(0, 8'h15), 8'h01, "R6 zero enable-off write no effect");

    // R2, R3, R7, R8 group0 rising edges
    src_in[1:0] = 2'b11;
    idle(5);
    rd(ra(0, 8'h10), 8'h03, "R2 raw status");
    rd(ra(0, 8'h18), 8'h03, "R3 rising edge latched");
    rd(16'h0550, 8'h01, "R7 summary group0");
    chk_irq(1'b1, "R8 host_irq asserted");
    wr(ra(0, 8'h15), 8'hFF);
    rd(ra(0, 8'h15), 8'h1F, "R9 unimplemented enable bits read 0");
    wr(ra(0, 8'h14), 8'h01);
    rd(ra(0, 8'h18), 8'h02, "R5 ack only written bit");
    wr(ra(0, 8'h14), 8'h02);
    rd(ra(0, 8'h18), 8'h00, "R5 ack edge source stays clear");
    idle(2);
    chk_irq(1'b0, "R8 host_irq released");

    // R3 group1 falling edge
    wr(ra(1, 8'h11), 8'hFF);
    rd(ra(1, 8'h11), 8'h01, "R9 group1 single source");
    wr(ra(1, 8'h13), 8'h01);
    wr(ra(1, 8'h15), 8'h01);
    src_in[8] = 1'b1;
    idle(5);
    rd(ra(1, 8'h18), 8'h00, "R3 falling sense ignores rise");
    src_in[8] = 1'b0;
    idle(5);
    rd(ra(1, 8'h18), 8'h01, "R3 falling edge latched");
    rd(16'h0550, 8'h02, "R7 summary group1");
    wr(ra(1, 8'h14), 8'h01);

    // R3 group2 both edges
    wr(ra(2, 8'h11), 8'h01);
    wr(ra(2, 8'h12), 8'h01);
    wr(ra(2, 8'h13), 8'h01);
    src_in[16] = 1'b1;
    idle(5);
    rd(ra(2, 8'h18), 8'h01, "R3 both-edge rise");
    wr(ra(2, 8'h14), 8'h01);
    rd(ra(2, 8'h18), 8'h00, "R5 ack group2");
    src_in[16] = 1'b0;
    idle(5);
    rd(ra(2, 8'h18), 8'h01, "R3 both-edge fall");

    // R4 group3 level
    wr(ra(3, 8'h12), 8'h01);
    src_in[24] = 1'b1;
    idle(5);
    rd(ra(3, 8'h18), 8'h01, "R4 level-high latched");
    wr(ra(3, 8'h14), 8'h01);
    rd(ra(3, 8'h18), 8'h01, "R4 level relatch after ack");
    src_in[24] = 1'b0;
    idle(5);
    wr(ra(3, 8'h14), 8'h01);
    rd(ra(3, 8'h18), 8'h00, "R4 level inactive stays clear");
    wr(ra(3, 8'h12), 8'h00);
    wr(ra(3, 8'h13), 8'h01);
    idle(2);
    rd(ra(3, 8'h18), 8'h01, "R4 level-low latched");

    // R1 unmapped addresses
    rd(ra(0, 8'h17), 8'h00, "R1 hole offset reads zero");
    rd(16'h1234, 8'h00, "R1 unmapped address reads zero");
    wr(ra(1, 8'h17), 8'hFF);
    rd(ra(1, 8'h15), 8'h01, "R1 hole write leaves enable");
    rd(ra(1, 8'h11), 8'h01, "R1 hole write leaves type");

    while (exp_q.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule